// File: doc/BRIEF.md
# I2C Power-Up Bus Recovery Sequencer

This block sits in front of the I2C master's boot loader. It runs once after each hard reset. It watches the synchronized clock and data lines to judge whether another master is already using the bus. When the bus looks free, it frees any slave that a reset left stuck in the middle of a byte. It then waits for a truly idle bus and fires a one-cycle pulse that lets the EEPROM boot read begin.

After reset, the block first lets its two-flop input synchronizers fill. It samples the data line once at that point. It then watches the clock line for a window of `IDLE_CYCLES` cycles. If the clock stayed high for the whole window, the block pulls the clock low nine times while leaving data released, then starts the boot load. If the clock dipped during the window, it skips that burst and waits instead for a STOP condition, or for both lines to stay high longer than the window. A data line that was low at the first sample, or a boot-disable strap, stops the boot from running. Even then the window still completes, and master transactions held back until then are released. With boot disabled, a status flag is set straight away, and that flag drives an interrupt when the enable input is high.

Top module: `i2c_powerup_recovery`

## Requirements
- R1: While reset is asserted, `sclPullLow`, `sdaPullLow`, `xferGrant`, `bootStart`, `bootOk` and `bootIrq` are all 0.
- R2: A transaction request is held (`xferGrant` = 0) until the idle window completes. The window is SYNC_STAGES+1 settle cycles plus IDLE_CYCLES watch cycles after reset release. After that, `xferGrant` follows `xferReq`.
- R3: If SCL reads low at any cycle of the watch window, no clock burst is sent and the block goes to wait-for-idle.
- R4: If SDA reads low at the first synchronized sample after reset, no burst is sent and `bootStart` never pulses. The window and the grant release still happen.
- R5: After a clean window with boot enabled, `sclPullLow` goes high exactly 9 times. Each low phase lasts HALF_CYCLES cycles, each high phase lasts HALF_CYCLES cycles, and `sdaPullLow` stays 0 throughout.
- R6: The burst is sent at most once per reset and is followed directly by `bootStart`.
- R7: In wait-for-idle, a STOP condition ends the wait and `bootStart` follows within a few cycles. A STOP is SDA rising while SCL is high in both the current and the previous synchronized sample.
- R8: In wait-for-idle, the wait also ends when SCL and SDA both read high for more than IDLE_CYCLES consecutive cycles. Any low reading on either line restarts this count.
- R9: With `bootDisable` = 1, `bootOk` is set in the first cycle after reset release. No burst is sent, `bootStart` never pulses, and the grant release still happens after the window.
- R10: `bootIrq` is 1 exactly when `bootOk` is 1 and `intEnable` is 1.
- R11: `bootStart` is a single-cycle pulse, issued at most once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| sclIn | input | 1 | SCL line level (asynchronous) |
| sdaIn | input | 1 | SDA line level (asynchronous) |
| bootDisable | input | 1 | Strap: 1 prevents the boot load |
| intEnable | input | 1 | Enables the interrupt from `bootOk` |
| xferReq | input | 1 | A master transaction wants to start |
| xferGrant | output | 1 | Transaction may start |
| sclPullLow | output | 1 | Open-drain pull-down enable for SCL |
| sdaPullLow | output | 1 | Open-drain pull-down enable for SDA |
| bootOk | output | 1 | Boot-OK status flag (set when boot is disabled) |
| bootIrq | output | 1 | Boot-OK interrupt |
| bootStart | output | 1 | One-cycle pulse: the boot read may begin |

## Verification
A wrong decision at the end of the watch window shows up on `sclPullLow` in the very next cycle: a burst that should not exist, or one that is missing. The pulse count and the phase widths expose a miscounting burst before `bootStart` fires. A wait-for-idle state that ignores STOP or restarts its count wrongly moves `bootStart` far out of its expected cycle range. It also makes the pulse appear where none is due. A window counter that is off shows on `xferGrant` against a request held since reset.

// File: rtl/recov_pkg.sv
package recov_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_WATCH,
    ST_BURST_LO,
    ST_BURST_HI,
    ST_WAIT_IDLE,
    ST_START,
    ST_DONE,
    ST_HALT
  } recovState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic latchSda;
    logic watchSample;
    logic windowEnd;
    logic pulseInc;
    logic setBootOk;
  } recovStrobe_t;

endpackage

// File: rtl/recov_datapath.sv
module recov_datapath
  import recov_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 10000,
  parameter int HALF_CYCLES = 500,
  parameter int PULSES      = 9,
  localparam int CNT_W      = $clog2(IDLE_CYCLES + SYNC_STAGES + HALF_CYCLES + 2),
  localparam int PULSE_W    = $clog2(PULSES + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  recovStrobe_t strb,
  output logic         settleDone,
  output logic         windowDone,
  output logic         halfDone,
  output logic         idleOver,
  output logic         pulsesDone,
  output logic         sclWasLow,
  output logic         sdaStuck,
  output logic         stopSeen,
  output logic         busHigh,
  output logic         windowOver,
  output logic         bootOk
);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [CNT_W-1:0] cnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic sclLowSeen;

  // two or more flop synchronizers, reset to the released level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSh[SYNC_STAGES-1];
  assign sdaS = sdaSh[SYNC_STAGES-1];

  // shared cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntEn)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (strb.pulseInc) pulseCnt <= pulseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowSeen <= 1'b0;
      sdaStuck   <= 1'b0;
      windowOver <= 1'b0;
      bootOk     <= 1'b0;
    end else begin
      if (strb.watchSample && !sclS) sclLowSeen <= 1'b1;
      if (strb.latchSda)             sdaStuck   <= ~sdaS;
      if (strb.windowEnd)            windowOver <= 1'b1;
      if (strb.setBootOk)            bootOk     <= 1'b1;
    end
  end

  assign settleDone = (cnt == CNT_W'(SYNC_STAGES));
  assign windowDone = (cnt == CNT_W'(IDLE_CYCLES - 1));
  assign halfDone   = (cnt == CNT_W'(HALF_CYCLES - 1));
  assign idleOver   = (cnt == CNT_W'(IDLE_CYCLES));
  assign pulsesDone = (pulseCnt == PULSE_W'(PULSES - 1));
  assign sclWasLow  = sclLowSeen | ~sclS;
  assign busHigh    = sclS & sdaS;
  assign stopSeen   = sdaS & ~sdaPrev & sclS & sclPrev;

endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import recov_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bootDisable,
  input  logic         settleDone,
  input  logic         windowDone,
  input  logic         halfDone,
  input  logic         idleOver,
  input  logic         pulsesDone,
  input  logic         sclWasLow,
  input  logic         sdaStuck,
  input  logic         stopSeen,
  input  logic         busHigh,
  output recovStrobe_t strb,
  output logic         sclPullLow,
  output logic         bootStart
);

  recovState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_SETTLE: begin
        strb.cntEn     = 1'b1;
        strb.setBootOk = bootDisable;
        if (settleDone) begin
          strb.cntClr   = 1'b1;
          strb.latchSda = 1'b1;
          nextState     = ST_WATCH;
        end
      end
      ST_WATCH: begin
        strb.cntEn       = 1'b1;
        strb.watchSample = 1'b1;
        if (windowDone) begin
          strb.cntClr    = 1'b1;
          strb.windowEnd = 1'b1;
          if (sdaStuck)         nextState = ST_HALT;
          else if (bootDisable) nextState = ST_DONE;
          else if (sclWasLow)   nextState = ST_WAIT_IDLE;
          else                  nextState = ST_BURST_LO;
        end
      end
      ST_BURST_LO: begin
        strb.cntEn = 1'b1;
        if (halfDone) begin
          strb.cntClr = 1'b1;
          nextState   = ST_BURST_HI;
        end
      end
      ST_BURST_HI: begin
        strb.cntEn = 1'b1;
        if (halfDone) begin
          strb.cntClr   = 1'b1;
          strb.pulseInc = 1'b1;
          nextState     = pulsesDone ? ST_START : ST_BURST_LO;
        end
      end
      ST_WAIT_IDLE: begin
        if (stopSeen || idleOver) begin
          strb.cntClr = 1'b1;
          nextState   = ST_START;
        end else if (busHigh) begin
          strb.cntEn = 1'b1;
        end else begin
          strb.cntClr = 1'b1;
        end
      end
      ST_START: nextState = ST_DONE;
      ST_DONE:  nextState = ST_DONE;
      ST_HALT:  nextState = ST_HALT;
      default:  nextState = ST_HALT;
    endcase
  end

  assign sclPullLow = (state == ST_BURST_LO);
  assign bootStart  = (state == ST_START);

endmodule

// File: rtl/i2c_powerup_recovery.sv
module i2c_powerup_recovery
  import recov_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 10000,
  parameter int HALF_CYCLES = 500,
  parameter int PULSES      = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic bootDisable,
  input  logic intEnable,
  input  logic xferReq,
  output logic xferGrant,
  output logic sclPullLow,
  output logic sdaPullLow,
  output logic bootOk,
  output logic bootIrq,
  output logic bootStart
);

  recovStrobe_t strb;
  logic settleDone, windowDone, halfDone, idleOver, pulsesDone;
  logic sclWasLow, sdaStuck, stopSeen, busHigh, windowOver;

  recov_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_CYCLES(IDLE_CYCLES),
    .HALF_CYCLES(HALF_CYCLES),
    .PULSES     (PULSES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .settleDone(settleDone), .windowDone(windowDone), .halfDone(halfDone),
    .idleOver(idleOver), .pulsesDone(pulsesDone), .sclWasLow(sclWasLow),
    .sdaStuck(sdaStuck), .stopSeen(stopSeen), .busHigh(busHigh),
    .windowOver(windowOver), .bootOk(bootOk)
  );

  recov_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bootDisable(bootDisable),
    .settleDone(settleDone), .windowDone(windowDone), .halfDone(halfDone),
    .idleOver(idleOver), .pulsesDone(pulsesDone), .sclWasLow(sclWasLow),
    .sdaStuck(sdaStuck), .stopSeen(stopSeen), .busHigh(busHigh),
    .strb(strb), .sclPullLow(sclPullLow), .bootStart(bootStart)
  );

  assign xferGrant  = xferReq & windowOver;
  assign bootIrq    = bootOk & intEnable;
  assign sdaPullLow = 1'b0;  // data always released

endmodule

// File: rtl/recov_checker.sv
module recov_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 10000,
  parameter int PULSES      = 9,
  localparam int LIMIT      = SYNC_STAGES + 1 + IDLE_CYCLES,
  localparam int LIM_W      = $clog2(LIMIT + 1),
  localparam int PC_W       = $clog2(PULSES + 2)
) (
  input logic clk,
  input logic rstN,
  input logic sclPullLow,
  input logic xferReq,
  input logic xferGrant,
  input logic bootStart,
  input logic bootDisable,
  input logic bootOk,
  input logic bootIrq,
  input logic intEnable
);

  logic [LIM_W-1:0] sinceRst;
  logic [PC_W-1:0]  riseCnt;
  logic             started;
  logic             sclPrevDrv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst   <= '0;
      riseCnt    <= '0;
      started    <= 1'b0;
      sclPrevDrv <= 1'b0;
    end else begin
      if (sinceRst != LIM_W'(LIMIT)) sinceRst <= sinceRst + 1'b1;
      if (sclPullLow && !sclPrevDrv) riseCnt <= riseCnt + 1'b1;
      if (bootStart) started <= 1'b1;
      sclPrevDrv <= sclPullLow;
    end
  end

  AST_GRANT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    xferGrant |-> (xferReq && sinceRst == LIM_W'(LIMIT)));  // R2
  AST_BURST_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (sclPullLow && !sclPrevDrv) |-> sinceRst == LIM_W'(LIMIT));  // R3
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (sclPullLow && !sclPrevDrv) |-> riseCnt < PC_W'(PULSES));  // R5
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bootStart |=> !bootStart);  // R11
  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    bootStart |-> !started);  // R11
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    bootStart |-> !bootDisable);  // R9
  AST_NO_BURST_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    bootDisable |-> !sclPullLow);  // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    bootIrq == (bootOk && intEnable));  // R10
  AST_BURST_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    sclPullLow |-> !started);  // R6

endmodule

bind i2c_powerup_recovery recov_checker #(
  .SYNC_STAGES(SYNC_STAGES),
  .IDLE_CYCLES(IDLE_CYCLES),
  .PULSES     (PULSES)
) chk (
  .clk(clk), .rstN(rstN), .sclPullLow(sclPullLow), .xferReq(xferReq),
  .xferGrant(xferGrant), .bootStart(bootStart), .bootDisable(bootDisable),
  .bootOk(bootOk), .bootIrq(bootIrq), .intEnable(intEnable)
);

// File: tb/tb_i2c_powerup_recovery.sv
module tb_i2c_powerup_recovery;

  localparam int SYNC = 2;
  localparam int IDLE = 40;
  localparam int HALF = 3;
  localparam int NPUL = 9;
  localparam int WIN_END = SYNC + 1 + IDLE;  // cycles to window completion

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclExt = 1'b1, sdaExt = 1'b1;
  logic bootDisable = 1'b0, intEnable = 1'b0, xferReq = 1'b0;
  logic xferGrant, sclPullLow, sdaPullLow, bootOk, bootIrq, bootStart;
  logic sclLine, sdaLine;

  always #2.5 clk = ~clk;  // 200 MHz

  assign sclLine = sclPullLow ? 1'b0 : sclExt;
  assign sdaLine = sdaPullLow ? 1'b0 : sdaExt;

  i2c_powerup_recovery #(
    .SYNC_STAGES(SYNC), .IDLE_CYCLES(IDLE), .HALF_CYCLES(HALF), .PULSES(NPUL)
  ) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .bootDisable(bootDisable), .intEnable(intEnable), .xferReq(xferReq),
    .xferGrant(xferGrant), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .bootOk(bootOk), .bootIrq(bootIrq), .bootStart(bootStart)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // monitor observations
  int cyc = 0;
  int pulses, lowRun, highRun, phaseBad, sdaPulled, starts, startCyc, startWideBad;
  logic prevStart, prevPull;

  typedef struct {
    string req;
    string what;
    int    exp;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver side: push expectations for the scenario
  task automatic expectItem(input string req, input string what, input int exp);
    expItem_t it;
    it.req = req; it.what = what; it.exp = exp;
    expQ.push_back(it);
  endtask

  function automatic int actualOf(input string what);
    case (what)
      "pulses":    return pulses;
      "phaseBad":  return phaseBad;
      "sdaPulled": return sdaPulled;
      "starts":    return starts;
      "startWide": return startWideBad;
      default:     return -1;
    endcase
  endfunction

  // scoreboard: pop every expected item and compare with observations
  task automatic scoreScenario();
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.req, it.what, actualOf(it.what), it.exp);
    end
  endtask

  // monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      pulses = 0; lowRun = 0; highRun = 0; phaseBad = 0; sdaPulled = 0;
      starts = 0; startCyc = -1; startWideBad = 0;
      prevStart = 1'b0; prevPull = 1'b0;
    end else begin
      if (sdaPullLow) sdaPulled = 1;
      if (sclPullLow) begin
        if (!prevPull) begin
          pulses++;
          if (pulses > 1 && highRun != HALF) phaseBad = 1;
          lowRun = 0;
        end
        lowRun++;
      end else begin
        if (prevPull) begin
          if (lowRun != HALF) phaseBad = 1;
          highRun = 0;
        end
        highRun++;
      end
      if (bootStart) begin
        if (prevStart) startWideBad = 1;
        else begin
          starts++;
          if (startCyc < 0) startCyc = cyc;
        end
      end
      prevStart = bootStart;
      prevPull  = sclPullLow;
    end
  end

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic waitTo(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic doReset(input logic scl, input logic sda, input logic dis, input logic ie);
    @(negedge clk);
    rstN = 1'b0;
    sclExt = scl; sdaExt = sda; bootDisable = dis; intEnable = ie; xferReq = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "sclPullLow in reset", sclPullLow, 0);
    check("R1", "bootStart in reset", bootStart, 0);
    check("R1", "xferGrant in reset", xferGrant, 0);
    check("R1", "bootOk in reset", bootOk, 0);
    check("R1", "bootIrq in reset", bootIrq, 0);
    check("R1", "sdaPullLow in reset", sdaPullLow, 0);
    cyc = 0;
    rstN = 1'b1;
  endtask

  function automatic int inRange(input int v, input int lo, input int hi);
    return (v >= lo && v <= hi) ? 1 : 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // S1: quiet bus, boot enabled -> burst then start
    doReset(1'b1, 1'b1, 1'b0, 1'b1);
    waitTo(WIN_END - 10);
    check("R2", "grant held during window", xferGrant, 0);
    waitTo(WIN_END + 3);
    check("R2", "grant after window", xferGrant, 1);
    xferReq = 1'b0;
    @(negedge clk);
    check("R2", "grant follows request", xferGrant, 0);
    xferReq = 1'b1;
    waitTo(200);
    expectItem("R5", "pulses", NPUL);
    expectItem("R5", "phaseBad", 0);
    expectItem("R5", "sdaPulled", 0);
    expectItem("R6", "starts", 1);
    expectItem("R11", "startWide", 0);
    scoreScenario();
    check("R6", "start right after burst", inRange(startCyc, WIN_END + 2*HALF*NPUL - 4, WIN_END + 2*HALF*NPUL + 4), 1);
    check("R10", "irq with bootOk clear", bootIrq, 0);
    check("R9", "bootOk clear when enabled", bootOk, 0);

    // S2: SCL low in window, other master, then STOP
    doReset(1'b1, 1'b1, 1'b0, 1'b0);
    waitTo(10); sclExt = 1'b0; sdaExt = 1'b0;
    waitTo(15); sclExt = 1'b1;
    waitTo(70);
    check("R7", "no start before STOP", starts, 0);
    sdaExt = 1'b1;
    waitTo(120);
    expectItem("R3", "pulses", 0);
    expectItem("R7", "starts", 1);
    expectItem("R11", "startWide", 0);
    scoreScenario();
    check("R7", "start soon after STOP", inRange(startCyc, 70, 77), 1);

    // S3: SCL low in window, then idle timeout with one restart
    doReset(1'b1, 1'b1, 1'b0, 1'b0);
    waitTo(10); sclExt = 1'b0;
    waitTo(15); sclExt = 1'b1;
    waitTo(60); sclExt = 1'b0;
    waitTo(62); sclExt = 1'b1;
    waitTo(62 + IDLE);
    check("R8", "no start before idle count restarts out", starts, 0);
    waitTo(160);
    expectItem("R3", "pulses", 0);
    expectItem("R8", "starts", 1);
    scoreScenario();
    check("R8", "start after idle timeout", inRange(startCyc, 62 + IDLE, 62 + IDLE + 8), 1);

    // S4: SDA stuck low at reset exit
    doReset(1'b1, 1'b0, 1'b0, 1'b0);
    waitTo(WIN_END + 3);
    check("R4", "grant after window despite stuck SDA", xferGrant, 1);
    sdaExt = 1'b1;  // bus later frees; still no boot
    waitTo(250);
    expectItem("R4", "pulses", 0);
    expectItem("R4", "starts", 0);
    scoreScenario();

    // S5: boot disabled, interrupt off then on
    doReset(1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    check("R9", "bootOk set at once", bootOk, 1);
    check("R10", "irq masked", bootIrq, 0);
    waitTo(WIN_END - 10);
    check("R9", "window still holds grant", xferGrant, 0);
    waitTo(WIN_END + 3);
    check("R9", "grant after window when disabled", xferGrant, 1);
    intEnable = 1'b1;
    @(negedge clk);
    check("R10", "irq when enabled", bootIrq, 1);
    waitTo(200);
    expectItem("R9", "pulses", 0);
    expectItem("R9", "starts", 0);
    scoreScenario();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule